// File: doc/BRIEF.md
# Sampled Noise Filter with Edge Detection

This block cleans up slow external trigger and interrupt inputs before they reach edge-sensitive logic. Each channel looks at its pin only in clock cycles where the sampling strobe is high. It adopts a new level only once that level has been seen on a run of identical consecutive samples. Rising and falling edge pulses come from the filtered level, never from the raw pin, and each direction has its own enable per channel.

All channels but one use a fixed run of three samples. The remaining channel has a 2-bit length select. A per-channel bypass input turns a channel into a plain port input: its level then tracks the pin every clock with no qualification. Pins are taken to be synchronous to `clk` already; any pad synchronizer sits outside this block.

Top module: `noise_filter_edge`

## Requirements
- R1: On a fixed-length channel, the filtered level takes a new pin value in the clock cycle of the third identical consecutive sample. The first and second samples of the run leave it unchanged.
- R2: A run of only one or two samples of a value that differs from the filtered level, followed by a return to the filtered value, leaves the filtered level unchanged.
- R3: Only clock edges with `sample_en` high count as samples. Edges with `sample_en` low neither extend nor break a run, and the filtered level does not change on them.
- R4: On the programmable channel (index NUM_CH-1), the required run length is 3 when `width_sel`=0, 4 when it is 1, 8 when it is 2 and 16 when it is 3. The level changes on the sample that completes the run and not on the one before it.
- R5: When the filtered level of a channel goes from 0 to 1 and that channel's `rise_en` bit was high, `rise_pulse` for that channel is high for exactly the one cycle in which the new level first appears.
- R6: When the filtered level goes from 1 to 0 and that channel's `fall_en` bit was high, `fall_pulse` for that channel is high for exactly the one cycle in which the new level first appears.
- R7: With its enable bit low, a channel produces no pulse in that direction, but its filtered level still updates.
- R8: While a channel's `bypass` bit is high, its level equals the pin value registered on every clock, whatever `sample_en` is, and edges of that level still produce pulses.
- R9: Reset (active low, asynchronous) forces every filtered level to 0 and every pulse to 0, with no pulse produced on release. A new level then has to build a full run from scratch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Sampling strobe; a clock edge with this high is one sample |
| width_sel | input | 2 | Run length select for the programmable channel |
| pin_in | input | NUM_CH | Raw pin levels, synchronous to clk |
| bypass | input | NUM_CH | Per-channel plain-input mode, no filtering |
| rise_en | input | NUM_CH | Per-channel rising edge pulse enable |
| fall_en | input | NUM_CH | Per-channel falling edge pulse enable |
| level_out | output | NUM_CH | Filtered levels |
| rise_pulse | output | NUM_CH | One-cycle rising edge pulses |
| fall_pulse | output | NUM_CH | One-cycle falling edge pulses |

## Verification
The assertions take for granted that `pin_in` and `bypass` are already synchronous to `clk`, and that `width_sel` does not move while the programmable channel is part-way through a run. Without the first, the registered pin could be metastable. Without the second, the run length would change mid-count. The stimulus changes every input only on the falling clock edge. It sets `width_sel` only after the programmable channel has settled and before the next run begins. It drives bypassed channels in the same synchronous way.

// File: rtl/nf_pkg.sv
package nf_pkg;

    localparam int unsigned NF_SEL_W   = 2;
    localparam int unsigned NF_MAX_LEN = 1 << (1 << NF_SEL_W);
    localparam int unsigned NF_CNT_W   = $clog2(NF_MAX_LEN + 1);

    typedef logic [NF_CNT_W-1:0] nf_cnt_t;
    typedef logic [NF_SEL_W-1:0] nf_sel_t;

    // per-channel filter state
    typedef struct packed {
        logic    prev;   // last sampled pin value
        nf_cnt_t cnt;    // length of the current identical run
        logic    level;  // accepted (filtered) level
    } nf_chan_st_t;

    // per-channel edge pulse state
    typedef struct packed {
        logic rise;
        logic fall;
    } nf_edge_st_t;

    // length select: 0 -> 3, k -> 2^(k+1) otherwise
    function automatic nf_cnt_t nf_run_len(input nf_sel_t sel);
        if (sel == '0) begin
            return nf_cnt_t'(3);
        end
        return nf_cnt_t'(1) << (int'(sel) + 1);
    endfunction

endpackage

// File: rtl/nf_len_sel.sv
module nf_len_sel
    import nf_pkg::*;
#(
    parameter int unsigned NUM_CH  = 4,
    parameter int unsigned PROG_CH = NUM_CH - 1,
    parameter int unsigned FIX_LEN = 3
) (
    input  nf_sel_t width_sel,
    output nf_cnt_t run_len [NUM_CH]
);

    localparam nf_cnt_t FIX_CNT = nf_cnt_t'(FIX_LEN);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_len
        if (ch == PROG_CH) begin : g_prog
            assign run_len[ch] = nf_run_len(width_sel);
        end else begin : g_fix
            assign run_len[ch] = FIX_CNT;
        end
    end

endmodule

// File: rtl/nf_chan_filter.sv
module nf_chan_filter
    import nf_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sample_en,
    input  logic    pin,
    input  logic    bypass,
    input  nf_cnt_t run_len,
    output logic    level_q,
    output logic    level_d
);

    localparam nf_cnt_t CNT_CAP = nf_cnt_t'(NF_MAX_LEN);

    nf_chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bypass) begin
            st_d.prev  = pin;
            st_d.cnt   = '0;
            st_d.level = pin;
        end else if (sample_en) begin
            if (pin != st_q.prev) begin
                st_d.prev = pin;
                st_d.cnt  = nf_cnt_t'(1);
            end else if (st_q.cnt < CNT_CAP) begin
                st_d.cnt = st_q.cnt + nf_cnt_t'(1);
            end
            if (st_d.cnt >= run_len) begin
                st_d.level = pin;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_q = st_q.level;
    assign level_d = st_d.level;

    AST_LONE_SAMPLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && sample_en && pin != st_q.prev) |=> $stable(level_q)); // R2

    AST_NO_STROBE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && !sample_en) |=> $stable(level_q)); // R3

    AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_CAP); // R4

    AST_BYPASS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> level_q == $past(pin)); // R8

endmodule

// File: rtl/nf_edge_unit.sv
module nf_edge_unit
    import nf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_q,
    input  logic level_d,
    input  logic rise_en,
    input  logic fall_en,
    output logic rise,
    output logic fall
);

    nf_edge_st_t eg_d, eg_q;

    always_comb begin
        eg_d      = '0;
        eg_d.rise = rise_en & level_d & ~level_q;
        eg_d.fall = fall_en & ~level_d & level_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eg_q <= '0;
        end else begin
            eg_q <= eg_d;
        end
    end

    assign rise = eg_q.rise;
    assign fall = eg_q.fall;

    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall)); // R5

endmodule

// File: rtl/noise_filter_edge.sv
module noise_filter_edge
    import nf_pkg::*;
#(
    parameter int unsigned NUM_CH  = 4,
    parameter int unsigned FIX_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic [1:0]        width_sel,
    input  logic [NUM_CH-1:0] pin_in,
    input  logic [NUM_CH-1:0] bypass,
    input  logic [NUM_CH-1:0] rise_en,
    input  logic [NUM_CH-1:0] fall_en,
    output logic [NUM_CH-1:0] level_out,
    output logic [NUM_CH-1:0] rise_pulse,
    output logic [NUM_CH-1:0] fall_pulse
);

    localparam int unsigned PROG_CH = NUM_CH - 1;

    nf_cnt_t           run_len [NUM_CH];
    logic [NUM_CH-1:0] lvl_next;

    nf_len_sel #(
        .NUM_CH  (NUM_CH),
        .PROG_CH (PROG_CH),
        .FIX_LEN (FIX_LEN)
    ) u_len (
        .width_sel (nf_sel_t'(width_sel)),
        .run_len   (run_len)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        nf_chan_filter u_filt (
            .clk       (clk),
            .rst_n     (rst_n),
            .sample_en (sample_en),
            .pin       (pin_in[ch]),
            .bypass    (bypass[ch]),
            .run_len   (run_len[ch]),
            .level_q   (level_out[ch]),
            .level_d   (lvl_next[ch])
        );

        nf_edge_unit u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .level_q (level_out[ch]),
            .level_d (lvl_next[ch]),
            .rise_en (rise_en[ch]),
            .fall_en (fall_en[ch]),
            .rise    (rise_pulse[ch]),
            .fall    (fall_pulse[ch])
        );

        AST_RISE_MATCHES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            rise_pulse[ch] |-> (level_out[ch] && !$past(level_out[ch]))); // R5

        AST_FALL_MATCHES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            fall_pulse[ch] |-> (!level_out[ch] && $past(level_out[ch]))); // R6

        AST_RISE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            rise_pulse[ch] |-> $past(rise_en[ch])); // R7

        AST_FALL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            fall_pulse[ch] |-> $past(fall_en[ch])); // R7

        AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            rise_pulse[ch] |=> !rise_pulse[ch]); // R5
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |-> (level_out == '0 && rise_pulse == '0 && fall_pulse == '0)); // R9

endmodule

// File: tb/noise_filter_edge_bench.sv
`timescale 1ns/1ps
module noise_filter_edge_bench;

    localparam int NCH = 4;
    localparam int PCH = NCH - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           sample_en = 1'b0;
    logic [1:0]     width_sel = 2'd0;
    logic [NCH-1:0] pin_in = '0;
    logic [NCH-1:0] bypass = '0;
    logic [NCH-1:0] rise_en = '1;
    logic [NCH-1:0] fall_en = '1;
    logic [NCH-1:0] level_out, rise_pulse, fall_pulse;

    noise_filter_edge #(.NUM_CH(NCH)) u_noise_filter_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_en  (sample_en),
        .width_sel  (width_sel),
        .pin_in     (pin_in),
        .bypass     (bypass),
        .rise_en    (rise_en),
        .fall_en    (fall_en),
        .level_out  (level_out),
        .rise_pulse (rise_pulse),
        .fall_pulse (fall_pulse)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int    cyc;
        int    ch;
        logic  lvl;
        logic  r;
        logic  f;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // monitor: pops expectations due this cycle, samples 1 ns after the edge
    always @(posedge clk) begin
        cyc = cyc + 1;
        #1;
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            check(level_out[e.ch] === e.lvl, e.tag, $sformatf("ch%0d level", e.ch),
                  int'(level_out[e.ch]), int'(e.lvl));
            check(rise_pulse[e.ch] === e.r, e.tag, $sformatf("ch%0d rise", e.ch),
                  int'(rise_pulse[e.ch]), int'(e.r));
            check(fall_pulse[e.ch] === e.f, e.tag, $sformatf("ch%0d fall", e.ch),
                  int'(fall_pulse[e.ch]), int'(e.f));
        end
    end

    // driver: inputs are already set at this falling edge; expect after next rise
    task automatic tick(input int ch, input logic lvl, input logic r, input logic f,
                        input string tag);
        exp_t e;
        e = '{cyc + 1, ch, lvl, r, f, tag};
        sb.push_back(e);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: held in reset
        check(level_out == '0, "R9", "reset level", int'(level_out), 0);
        check(rise_pulse == '0 && fall_pulse == '0, "R9", "reset pulses",
              int'(rise_pulse | fall_pulse), 0);
        rst_n     = 1'b1;
        sample_en = 1'b1;
        tick(0, 0, 0, 0, "R9");

        // R1 / R5: ch0 rises after the third matching sample
        pin_in[0] = 1'b1;
        for (int k = 1; k <= 3; k++) tick(0, k == 3, k == 3, 0, (k == 3) ? "R5" : "R1");
        tick(0, 1, 0, 0, "R5");

        // R2: short pulses on ch1 rejected
        pin_in[1] = 1'b1;
        tick(1, 0, 0, 0, "R2");
        tick(1, 0, 0, 0, "R2");
        pin_in[1] = 1'b0;
        tick(1, 0, 0, 0, "R2");
        pin_in[1] = 1'b1;
        tick(1, 0, 0, 0, "R2");
        pin_in[1] = 1'b0;
        tick(1, 0, 0, 0, "R2");
        tick(1, 0, 0, 0, "R2");

        // R3: strobe gaps do not count or break the run
        pin_in[2] = 1'b1;
        begin
            bit pat [6] = '{1, 0, 0, 1, 0, 1};
            int seen = 0;
            for (int k = 0; k < 6; k++) begin
                sample_en = pat[k];
                if (pat[k]) seen++;
                tick(2, (seen == 3), (seen == 3) && pat[k], 0, "R3");
            end
        end
        sample_en = 1'b1;
        tick(2, 1, 0, 0, "R3");

        // R6: ch0 falls after three low samples
        pin_in[0] = 1'b0;
        for (int k = 1; k <= 3; k++) tick(0, k != 3, 0, k == 3, "R6");
        tick(0, 0, 0, 0, "R6");

        // R7: disabled directions give no pulse, level still moves
        rise_en[1] = 1'b0;
        pin_in[1]  = 1'b1;
        for (int k = 1; k <= 3; k++) tick(1, k == 3, 0, 0, "R7");
        rise_en[1] = 1'b1;
        fall_en[1] = 1'b0;
        pin_in[1]  = 1'b0;
        for (int k = 1; k <= 3; k++) tick(1, k != 3, 0, 0, "R7");
        tick(1, 0, 0, 0, "R7");
        fall_en[1] = 1'b1;

        // R4: programmable channel lengths 3, 4, 8, 16
        for (int s = 0; s < 4; s++) begin
            int len;
            len       = (s == 0) ? 3 : (1 << (s + 1));
            width_sel = 2'(s);
            pin_in[PCH] = 1'b1;
            for (int k = 1; k <= len; k++) tick(PCH, k == len, k == len, 0, "R4");
            pin_in[PCH] = 1'b0;
            for (int k = 1; k <= len; k++) tick(PCH, k != len, 0, k == len, "R4");
        end

        // R8: bypass follows the pin every clock, strobe off
        sample_en = 1'b0;
        bypass[2] = 1'b1;
        pin_in[2] = 1'b0;
        tick(2, 0, 0, 1, "R8");
        pin_in[2] = 1'b1;
        tick(2, 1, 1, 0, "R8");
        pin_in[2] = 1'b0;
        tick(2, 0, 0, 1, "R8");
        tick(2, 0, 0, 0, "R8");
        bypass[2] = 1'b0;
        sample_en = 1'b1;
        tick(2, 0, 0, 0, "R8");

        // R9: reset mid-run clears level, run rebuilds from scratch
        pin_in[0] = 1'b1;
        for (int k = 1; k <= 3; k++) tick(0, k == 3, k == 3, 0, "R1");
        rst_n = 1'b0;
        #1;
        check(level_out == '0, "R9", "level in reset", int'(level_out), 0);
        check(rise_pulse == '0 && fall_pulse == '0, "R9", "pulses in reset",
              int'(rise_pulse | fall_pulse), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 1; k <= 3; k++) tick(0, k == 3, k == 3, 0, "R9");

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R9", "unconsumed expectations", sb.size(), 0);
        report();
    end

endmodule